// File: doc/BRIEF.md
# Program Counter and Address Generator

This block owns the program counter of a simple in-order pipeline and works out, from the current instruction word and two register operands, every address the instruction needs. These are the effective address of a load or store, the target of a relative branch, and the target of a jump through a register. A step enable commits the computed next PC. When it is low, the PC stays where it is while the combinational outputs still reflect the present instruction.

Control transfers take effect on the very next step, with no delay slot. Linking transfers (the unconditional branch and the register jump) ask for the return address, the PC plus 4, to be written into the register named by the instruction's first register field. Quadword loads and stores whose address is not a multiple of 8 raise an alignment fault flag. The fault does not change the PC sequence; the consumer decides what to do with it.

Top module: `agen_npc`

## Requirements
- R1: While `rst_n` is low the PC is forced to 0; after release it reads 0 until the first enabled step.
- R2: On a clock edge with `step_en` high the PC takes the value shown on `next_pc`; with `step_en` low the PC is unchanged.
- R3: The opcode is `instr[31:26]`. For any opcode not listed in R4 to R8, `next_pc` is the PC plus 4, `link_we` is 0 and `align_fault` is 0.
- R4: For opcodes 0x08 (quadword load), 0x09 (quadword store) and 0x0A (longword load), `ea` equals `rb_val` plus `instr[15:0]` sign-extended to 64 bits, and `next_pc` is the PC plus 4.
- R5: `align_fault` is 1 exactly when the opcode is 0x08 or 0x09 and `ea[2:0]` is not zero. Opcode 0x0A never faults.
- R6: Opcode 0x10 is an unconditional branch. `next_pc` is (PC+4) plus `instr[20:0]` shifted left by 2 and sign-extended. `link_we` is 1, `link_idx` is `instr[25:21]` and `link_data` is PC+4.
- R7: Opcodes 0x11 to 0x15 are conditional branches on `ra_val`: 0x11 taken if zero, 0x12 if non-zero, 0x13 if bit 63 is set, 0x14 if bit 63 is clear, and 0x15 if bit 0 is set. A taken branch gives the R6 target and a not-taken one gives PC+4. No link is requested.
- R8: Opcode 0x18 is a jump. `next_pc` is `rb_val` with bits 1:0 cleared, and the link request is as in R6.
- R9: There is no delay slot: after an enabled step on a taken branch or jump, the PC equals the target directly. The PC is always a multiple of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Commit `next_pc` into the PC on this edge |
| instr | input | 32 | Current instruction word |
| ra_val | input | 64 | Value of the first register operand |
| rb_val | input | 64 | Value of the second register operand |
| pc | output | 64 | Current program counter |
| next_pc | output | 64 | PC the next step will load |
| ea | output | 64 | Base plus displacement address |
| link_we | output | 1 | Request to write the return address |
| link_idx | output | 5 | Destination register of the return address |
| link_data | output | 64 | Return address (PC+4) |
| align_fault | output | 1 | Misaligned quadword memory access |

## Verification
On every cycle the assertions check four things. The PC stays word aligned. It holds while stepping is off. It advances by exactly 4 or by exactly the branch offset plus 4 according to whether a transfer was taken, and a jump lands on the masked register value. They also tie any fault to a quadword opcode that requests no link. The condition truth table per opcode, the sign extension of negative displacements, the choice of link register and the split between faulting and non-faulting widths only show up in the bench's vector table and directed cases. The same applies to the reset value.

// File: rtl/agen_npc.sv
module agen_npc #(
  parameter int AW = 64,
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [IW-1:0] instr,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] ea,
  output logic          link_we,
  output logic [4:0]    link_idx,
  output logic [AW-1:0] link_data,
  output logic          align_fault
);
  localparam int MD_W = 16;
  localparam int BD_W = 21;
  localparam logic [5:0] OP_LDQ  = 6'h08;
  localparam logic [5:0] OP_STQ  = 6'h09;
  localparam logic [5:0] OP_LDL  = 6'h0A;
  localparam logic [5:0] OP_BR   = 6'h10;
  localparam logic [5:0] OP_BZ   = 6'h11;
  localparam logic [5:0] OP_BNZ  = 6'h12;
  localparam logic [5:0] OP_BNEG = 6'h13;
  localparam logic [5:0] OP_BPOS = 6'h14;
  localparam logic [5:0] OP_BODD = 6'h15;
  localparam logic [5:0] OP_JMP  = 6'h18;

  logic [AW-1:0] pc_q, pc_inc, mem_ofs, br_ofs, br_tgt;
  logic [5:0]    op;
  logic          take, is_jmp, is_quad;

  assign op      = instr[IW-1 -: 6];
  assign pc_inc  = pc_q + AW'(4);
  assign mem_ofs = {{(AW-MD_W){instr[MD_W-1]}}, instr[MD_W-1:0]};
  assign br_ofs  = {{(AW-BD_W-2){instr[BD_W-1]}}, instr[BD_W-1:0], 2'b00};
  assign br_tgt  = pc_inc + br_ofs;
  assign is_jmp  = (op == OP_JMP);
  assign is_quad = (op == OP_LDQ) || (op == OP_STQ);

  always_comb begin
    case (op)
      OP_BR:   take = 1'b1;
      OP_BZ:   take = (ra_val == '0);
      OP_BNZ:  take = (ra_val != '0);
      OP_BNEG: take = ra_val[AW-1];
      OP_BPOS: take = ~ra_val[AW-1];
      OP_BODD: take = ra_val[0];
      default: take = 1'b0;
    endcase
  end

  assign next_pc     = is_jmp ? {rb_val[AW-1:2], 2'b00} : (take ? br_tgt : pc_inc);
  assign ea          = rb_val + mem_ofs;
  assign align_fault = is_quad && (ea[2:0] != 3'b000);
  assign link_we     = (op == OP_BR) || is_jmp;
  assign link_idx    = instr[25:21];
  assign link_data   = pc_inc;
  assign pc          = pc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       pc_q <= '0;
    else if (step_en) pc_q <= next_pc;
  end

  AST_PC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q[1:0] == 2'b00); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(pc_q)); // R2
  AST_SEQ_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !take && !is_jmp) |=> (pc_q - $past(pc_q)) == AW'(4)); // R3
  AST_BR_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && take && !is_jmp) |=> (pc_q - $past(pc_q)) == $past(br_ofs) + AW'(4)); // R9
  AST_JMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && is_jmp) |=> pc_q == ($past(rb_val) & ~AW'(3))); // R8
  AST_FAULT_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> (is_quad && !link_we)); // R5
  AST_LINK_RET: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_data - pc) == AW'(4)); // R6
endmodule

// File: tb/agen_npc_tb.sv
`timescale 1ns/100ps
module agen_npc_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] ra_val = '0, rb_val = '0;
  logic [63:0] pc, next_pc, ea, link_data;
  logic        link_we, align_fault;
  logic [4:0]  link_idx;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  agen_npc dut_i (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .instr(instr),
    .ra_val(ra_val), .rb_val(rb_val), .pc(pc), .next_pc(next_pc), .ea(ea),
    .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
    .align_fault(align_fault));

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  ra;
    logic [20:0] low;
    logic [63:0] rav;
    logic [63:0] rbv;
    logic [63:0] exp_next;
    logic        chk_ea;
    logic [63:0] exp_ea;
    logic        exp_fault;
    logic        exp_link;
  } vec_t;

  localparam int NV = 20;
  // all vectors are applied with PC = 0x1000, so PC+4 = 0x1004
  localparam vec_t VEC [NV] = '{
    '{6'h00, 5'd0,  21'h000000, 64'h0, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h08, 5'd1,  21'h000010, 64'h0, 64'h2000, 64'h1004, 1'b1, 64'h2010, 1'b0, 1'b0},
    '{6'h08, 5'd1,  21'h00FFFC, 64'h0, 64'h2000, 64'h1004, 1'b1, 64'h1FFC, 1'b1, 1'b0},
    '{6'h09, 5'd2,  21'h000007, 64'h0, 64'h3001, 64'h1004, 1'b1, 64'h3008, 1'b0, 1'b0},
    '{6'h09, 5'd2,  21'h000001, 64'h0, 64'h3000, 64'h1004, 1'b1, 64'h3001, 1'b1, 1'b0},
    '{6'h0A, 5'd3,  21'h000002, 64'h0, 64'h2000, 64'h1004, 1'b1, 64'h2002, 1'b0, 1'b0},
    '{6'h10, 5'd26, 21'h000010, 64'h0, 64'h0, 64'h1044, 1'b0, 64'h0, 1'b0, 1'b1},
    '{6'h10, 5'd26, 21'h1FFFFF, 64'h0, 64'h0, 64'h1000, 1'b0, 64'h0, 1'b0, 1'b1},
    '{6'h11, 5'd4,  21'h000008, 64'h0, 64'h0, 64'h1024, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h11, 5'd4,  21'h000008, 64'h5, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h12, 5'd4,  21'h000008, 64'h5, 64'h0, 64'h1024, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h12, 5'd4,  21'h000008, 64'h0, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h13, 5'd4,  21'h1FFFF0, 64'h8000000000000000, 64'h0, 64'h0FC4, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h13, 5'd4,  21'h1FFFF0, 64'h1, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h14, 5'd4,  21'h000008, 64'h0, 64'h0, 64'h1024, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h14, 5'd4,  21'h000008, 64'hFFFFFFFFFFFFFFFF, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h15, 5'd4,  21'h000008, 64'h3, 64'h0, 64'h1024, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h15, 5'd4,  21'h000008, 64'h2, 64'h0, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0},
    '{6'h18, 5'd9,  21'h000000, 64'h0, 64'h4007, 64'h4004, 1'b0, 64'h0, 1'b0, 1'b1},
    '{6'h3F, 5'd9,  21'h000000, 64'h0, 64'h4007, 64'h1004, 1'b0, 64'h0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step_once();
    @(negedge clk); step_en = 1'b1;
    @(negedge clk); step_en = 1'b0;
    #1;
  endtask

  function automatic string req_of(input logic [5:0] op);
    if (op == 6'h08 || op == 6'h09 || op == 6'h0A) return "R4";
    if (op == 6'h10) return "R6";
    if (op >= 6'h11 && op <= 6'h15) return "R7";
    if (op == 6'h18) return "R8";
    return "R3";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pc == 64'h0, "R1 reset pc", pc, 64'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(pc == 64'h0, "R1 pc after release", pc, 64'h0);

    // R3 plain sequential step
    @(negedge clk); instr = {6'h00, 26'h0};
    step_once();
    chk(pc == 64'h4, "R3 sequential step", pc, 64'h4);

    // R2 step_en low holds pc despite a jump present
    @(negedge clk); instr = {6'h18, 5'd0, 21'h0}; rb_val = 64'h8888;
    repeat (3) @(negedge clk);
    #1;
    chk(pc == 64'h4, "R2 hold without step", pc, 64'h4);

    // R8 jump into 0x1000 area
    @(negedge clk); rb_val = 64'h1003;
    step_once();
    chk(pc == 64'h1000, "R8 jump masks low bits", pc, 64'h1000);

    // vector table at pc = 0x1000, no stepping
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      instr = {VEC[i].op, VEC[i].ra, VEC[i].low};
      ra_val = VEC[i].rav; rb_val = VEC[i].rbv;
      #1;
      chk(next_pc == VEC[i].exp_next, req_of(VEC[i].op), next_pc, VEC[i].exp_next);
      if (VEC[i].chk_ea)
        chk(ea == VEC[i].exp_ea, "R4 effective address", ea, VEC[i].exp_ea);
      chk(align_fault == VEC[i].exp_fault, "R5 alignment fault", 64'(align_fault), 64'(VEC[i].exp_fault));
      chk(link_we == VEC[i].exp_link, "R6 link request", 64'(link_we), 64'(VEC[i].exp_link));
      if (VEC[i].exp_link) begin
        chk(link_idx == VEC[i].ra, "R6 link index", 64'(link_idx), 64'(VEC[i].ra));
        chk(link_data == 64'h1004, "R6 link data", link_data, 64'h1004);
      end
    end
    chk(pc == 64'h1000, "R2 table did not move pc", pc, 64'h1000);

    // R9 taken branch lands directly on target
    @(negedge clk); instr = {6'h10, 5'd26, 21'h000010};
    step_once();
    chk(pc == 64'h1044, "R9 taken branch no slot", pc, 64'h1044);

    // R7 not-taken conditional advances by 4
    @(negedge clk); instr = {6'h11, 5'd1, 21'h000100}; ra_val = 64'h1;
    step_once();
    chk(pc == 64'h1048, "R7 not taken step", pc, 64'h1048);

    // R9 taken negative branch
    @(negedge clk); instr = {6'h13, 5'd1, 21'h1FFFFE}; ra_val = 64'hF000000000000000;
    step_once();
    chk(pc == 64'h1044, "R9 backward branch", pc, 64'h1044);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk(pc == 64'h0, "R1 reset mid-run", pc, 64'h0);
    rst_n = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule